// File: doc/BRIEF.md
# Command Queue Consumer

This block drains a circular ring of fixed-size commands that software places in memory. Software describes the ring with a base register (address, page count, valid bit), moves a write pointer forward as it adds commands, and watches the read pointer the block moves forward as it consumes them. For each slot between the read and write pointers, the block fetches the whole 32-byte command over a memory read port. It then decides whether the command needs an external handler. Commands that need one are presented on a handshaked dispatch port. Commands that need no work are consumed internally.

Each command ends in one of two ways. If it completes normally, the read pointer advances by one slot and wraps to zero at the end of the ring. If the handler reports a stall, or the memory fetch fails, the read pointer stays on the failing slot and a sticky stalled flag is raised. The register side also enforces the ring's configuration rules. Processing is gated by an enable bit. The ring base and the table base registers are frozen while enabled. The write pointer's retry bit is masked. The read pointer can only be written in a security-disabled mode.

Top module: `cmdq_consumer`

## Requirements
- R1: No command is fetched while the control register bit 0 (enable) is clear. A write that sets enable from clear starts a processing pass.
- R2: The ring holds (size+1)·128 slots, where size is ring-base bits [7:0] (4096-byte pages, 32-byte slots). The ring holds zero slots when ring-base bit 63 (valid) is clear.
- R3: When either pointer's offset is not below the slot count, nothing is fetched and both pointers keep their values.
- R4: The block keeps fetching while the write offset differs from the read offset. Each fetch reads from address (ring-base bits [51:12] << 12) + read offset × 32. Offsets sit in pointer bits [19:5].
- R5: When a command completes, the read offset becomes read offset + 1, wrapping to 0 when it reaches the slot count.
- R6: A handler stall or a fetch error sets the stalled flag (read pointer bit 0), leaves the read offset unchanged and ends the pass. The flag stays set while later passes run.
- R7: A write-pointer write never stores bit 0 (retry), which reads back 0. The write starts a pass only if the new offset differs from the read offset.
- R8: Writes to the ring-base register (address 1) and the table base registers (address 4 + n) are ignored while enabled. They take effect while disabled.
- R9: A read-pointer write is ignored unless the security-disabled input is high. An accepted write loads the offset and clears the stalled flag, and can never set it.
- R10: Opcode 0x05 (sync) is consumed without dispatch. Opcode 0x0E (move-all) is consumed without dispatch when word2[31:16] equals word3[31:16], and is dispatched otherwise.
- R11: The opcode is word0[7:0] (word k is mem_rdata[64k+63:64k]). Opcodes 0x01–0x0F are dispatched, apart from the cases in R10. All other opcodes are skipped as completed.
- R12: Once a command is presented on the dispatch port, cmd_valid, the opcode and the words hold until cmd_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write address: 0 control, 1 ring base, 2 write ptr, 3 read ptr, 4+n table n |
| reg_wdata | input | 64 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 64 | Register read data (combinational) |
| sec_off | input | 1 | Security-disabled mode, allows read-pointer writes |
| mem_req | output | 1 | Command fetch request, held until mem_rvalid |
| mem_addr | output | 52 | Fetch byte address |
| mem_rvalid | input | 1 | Fetch response valid |
| mem_rdata | input | 256 | Fetched command, four little-endian 64-bit words |
| mem_err | input | 1 | Fetch error, qualified by mem_rvalid |
| cmd_valid | output | 1 | Command presented to handlers |
| cmd_opcode | output | 8 | Opcode of the presented command |
| cmd_words | output | 256 | Full presented command |
| cmd_done | input | 1 | Handler finished the presented command |
| cmd_stall | input | 1 | Handler result is stall, qualified by cmd_done |

## Verification
The bench targets five corner cases. The first is the wrap from the last slot back to zero. A design that wraps at the wrong count, or never wraps, would fetch past the ring or leave the read pointer at 128. The second is the sticky stall. A design that clears the flag on the next pass, or that advances past a stalled or faulted slot, shows a wrong read-pointer value. The third covers out-of-range offsets and a cleared valid bit, where a fetch would show up as an extra memory request. The fourth is the set of internal no-ops. A move-all with equal fields, a sync, or an unknown opcode that reaches the handler shows up as an extra dispatch. The last covers the lock and mask rules: a frozen register that changes, a retry bit that reads back, or a rewrite of the same write pointer that starts a fetch all show up at the ports.

// File: rtl/cq_pkg.sv
package cq_pkg;

    localparam int REG_AW      = 3;
    localparam int WORD_W      = 64;
    localparam int CMD_WORDS   = 4;
    localparam int CMD_W       = WORD_W * CMD_WORDS;
    localparam int OPC_W       = 8;
    localparam int ENTRY_SHIFT = 5;   // 32-byte slots
    localparam int PAGE_SHIFT  = 12;  // 4096-byte pages
    localparam int QVALID_BIT  = 63;
    localparam int MV_LO       = 16;
    localparam int MV_HI       = 31;

    localparam logic [OPC_W-1:0] OP_FIRST    = 8'h01;
    localparam logic [OPC_W-1:0] OP_LAST     = 8'h0F;
    localparam logic [OPC_W-1:0] OP_SYNC     = 8'h05;
    localparam logic [OPC_W-1:0] OP_MOVE_ALL = 8'h0E;

    typedef enum logic [REG_AW-1:0] {
        RS_CTRL  = 3'd0,
        RS_QBASE = 3'd1,
        RS_WPTR  = 3'd2,
        RS_RPTR  = 3'd3,
        RS_TBL0  = 3'd4
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH,
        ST_SORT,
        ST_ISSUE
    } seq_state_e;

    typedef enum logic {
        ACT_SKIP,
        ACT_ISSUE
    } cmd_act_e;

    typedef struct packed {
        logic [WORD_W-1:0] w3;
        logic [WORD_W-1:0] w2;
        logic [WORD_W-1:0] w1;
        logic [WORD_W-1:0] w0;
    } cmd_t;

    function automatic logic op_in_range(input logic [OPC_W-1:0] op);
        return (op >= OP_FIRST) && (op <= OP_LAST);
    endfunction

endpackage

// File: rtl/cq_classify.sv
module cq_classify
    import cq_pkg::*;
(
    input  logic [OPC_W-1:0]       opcode,
    input  logic [MV_HI-MV_LO:0]   mv_src,
    input  logic [MV_HI-MV_LO:0]   mv_dst,
    output cmd_act_e               act
);

    always_comb begin
        if (!op_in_range(opcode)) begin
            act = ACT_SKIP;
        end else if (opcode == OP_SYNC) begin
            act = ACT_SKIP;
        end else if (opcode == OP_MOVE_ALL && mv_src == mv_dst) begin
            act = ACT_SKIP;
        end else begin
            act = ACT_ISSUE;
        end
    end

endmodule

// File: rtl/cq_regfile.sv
module cq_regfile
    import cq_pkg::*;
#(
    parameter int SIZE_W  = 8,
    parameter int ADDR_W  = 52,
    parameter int NUM_TBL = 2,
    localparam int OFF_W  = SIZE_W + 7
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_we,
    input  logic [REG_AW-1:0]        reg_waddr,
    input  logic [WORD_W-1:0]        reg_wdata,
    input  logic [REG_AW-1:0]        reg_raddr,
    output logic [WORD_W-1:0]        reg_rdata,
    input  logic                     sec_off,
    input  logic                     busy,
    input  logic                     hw_rd_load,
    input  logic [OFF_W-1:0]         hw_rd_val,
    input  logic                     hw_stall_set,
    output logic                     enable,
    output logic                     q_valid,
    output logic [ADDR_W-PAGE_SHIFT-1:0] q_page,
    output logic [SIZE_W-1:0]        q_size,
    output logic [OFF_W-1:0]         wr_off,
    output logic [OFF_W-1:0]         rd_off,
    output logic                     stalled,
    output logic                     kick
);

    localparam int OFF_LSB = ENTRY_SHIFT;
    localparam int OFF_MSB = ENTRY_SHIFT + OFF_W - 1;

    logic [NUM_TBL-1:0][WORD_W-1:0] tbl_q;
    logic [NUM_TBL-1:0]             tbl_hit;
    logic                           cfg_open;
    logic                           ctrl_wr, qbase_wr, wptr_wr, rptr_sw_wr;
    logic [OFF_W-1:0]               wr_new;

    assign cfg_open   = !enable && !busy;
    assign ctrl_wr    = reg_we && reg_waddr == RS_CTRL;
    assign qbase_wr   = reg_we && reg_waddr == RS_QBASE && cfg_open;
    assign wptr_wr    = reg_we && reg_waddr == RS_WPTR;
    assign rptr_sw_wr = reg_we && reg_waddr == RS_RPTR && sec_off && !busy;
    assign wr_new     = reg_wdata[OFF_MSB:OFF_LSB];

    for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl_hit
        assign tbl_hit[t] = reg_we && cfg_open &&
                            reg_waddr == REG_AW'(int'(RS_TBL0) + t);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable  <= 1'b0;
            q_valid <= 1'b0;
            q_page  <= '0;
            q_size  <= '0;
            wr_off  <= '0;
            rd_off  <= '0;
            stalled <= 1'b0;
            kick    <= 1'b0;
            tbl_q   <= '0;
        end else begin
            kick <= (ctrl_wr && reg_wdata[0] && !enable) ||
                    (wptr_wr && wr_new != rd_off);
            if (ctrl_wr) begin
                enable <= reg_wdata[0];
            end
            if (qbase_wr) begin
                q_valid <= reg_wdata[QVALID_BIT];
                q_page  <= reg_wdata[ADDR_W-1:PAGE_SHIFT];
                q_size  <= reg_wdata[SIZE_W-1:0];
            end
            if (wptr_wr) begin
                wr_off <= wr_new;
            end
            if (hw_rd_load) begin
                rd_off <= hw_rd_val;
            end else if (rptr_sw_wr) begin
                rd_off <= reg_wdata[OFF_MSB:OFF_LSB];
            end
            if (hw_stall_set) begin
                stalled <= 1'b1;
            end else if (rptr_sw_wr) begin
                stalled <= 1'b0;
            end
            for (int t = 0; t < NUM_TBL; t++) begin
                if (tbl_hit[t]) begin
                    tbl_q[t] <= reg_wdata;
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_raddr)
            RS_CTRL:  reg_rdata[0] = enable;
            RS_QBASE: begin
                reg_rdata[QVALID_BIT]             = q_valid;
                reg_rdata[ADDR_W-1:PAGE_SHIFT]    = q_page;
                reg_rdata[SIZE_W-1:0]             = q_size;
            end
            RS_WPTR:  reg_rdata[OFF_MSB:OFF_LSB] = wr_off;
            RS_RPTR: begin
                reg_rdata[OFF_MSB:OFF_LSB] = rd_off;
                reg_rdata[0]               = stalled;
            end
            default: begin
                for (int t = 0; t < NUM_TBL; t++) begin
                    if (reg_raddr == REG_AW'(int'(RS_TBL0) + t)) begin
                        reg_rdata = tbl_q[t];
                    end
                end
            end
        endcase
    end

    AST_STALL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stalled && !rptr_sw_wr) |=> stalled); // R6

    AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        enable |=> ($stable(q_valid) && $stable(q_page) && $stable(q_size))); // R8

    AST_RPTR_GUARDED: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_waddr == RS_RPTR && !sec_off && !hw_rd_load) |=> $stable(rd_off)); // R9

    AST_RPTR_NO_SET: assert property (@(posedge clk) disable iff (rst)
        (!stalled && !hw_stall_set) |=> !stalled); // R9

endmodule

// File: rtl/cq_sequencer.sv
module cq_sequencer
    import cq_pkg::*;
#(
    parameter int SIZE_W = 8,
    parameter int ADDR_W = 52,
    localparam int OFF_W = SIZE_W + 7
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     enable,
    input  logic                     kick,
    input  logic                     q_valid,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] q_page,
    input  logic [SIZE_W-1:0]        q_size,
    input  logic [OFF_W-1:0]         wr_off,
    input  logic [OFF_W-1:0]         rd_off,
    output logic                     busy,
    output logic                     rd_load,
    output logic [OFF_W-1:0]         rd_val,
    output logic                     stall_set,
    output logic                     mem_req,
    output logic [ADDR_W-1:0]        mem_addr,
    input  logic                     mem_rvalid,
    input  logic [CMD_W-1:0]         mem_rdata,
    input  logic                     mem_err,
    output logic                     cmd_valid,
    output logic [OPC_W-1:0]         cmd_opcode,
    output logic [CMD_W-1:0]         cmd_words,
    input  logic                     cmd_done,
    input  logic                     cmd_stall
);

    localparam int CNT_W     = SIZE_W + 8;
    localparam int PER_PAGE  = PAGE_SHIFT - ENTRY_SHIFT;

    seq_state_e         state, nxt;
    logic               pend;
    logic               cap;
    cmd_t               cmd_q;
    cmd_act_e           act;
    logic [CNT_W-1:0]   slot_cnt;
    logic [CNT_W-1:0]   rd_inc;
    logic               wr_ok, rd_ok;

    assign slot_cnt = q_valid ? ((CNT_W'(q_size) + CNT_W'(1)) << PER_PAGE) : '0;
    assign wr_ok    = CNT_W'(wr_off) < slot_cnt;
    assign rd_ok    = CNT_W'(rd_off) < slot_cnt;
    assign rd_inc   = CNT_W'(rd_off) + CNT_W'(1);
    assign rd_val   = (rd_inc == slot_cnt) ? '0 : rd_inc[OFF_W-1:0];

    assign busy       = state != ST_IDLE;
    assign mem_req    = state == ST_FETCH;
    assign mem_addr   = {q_page, {PAGE_SHIFT{1'b0}}} + (ADDR_W'(rd_off) << ENTRY_SHIFT);
    assign cmd_valid  = state == ST_ISSUE;
    assign cmd_opcode = cmd_q.w0[OPC_W-1:0];
    assign cmd_words  = cmd_q;

    cq_classify u_classify (
        .opcode (cmd_q.w0[OPC_W-1:0]),
        .mv_src (cmd_q.w2[MV_HI:MV_LO]),
        .mv_dst (cmd_q.w3[MV_HI:MV_LO]),
        .act    (act)
    );

    always_comb begin
        nxt       = state;
        rd_load   = 1'b0;
        stall_set = 1'b0;
        cap       = 1'b0;
        case (state)
            ST_IDLE: begin
                if (kick || pend) nxt = ST_CHECK;
            end
            ST_CHECK: begin
                if (!enable || !wr_ok || !rd_ok || wr_off == rd_off) nxt = ST_IDLE;
                else nxt = ST_FETCH;
            end
            ST_FETCH: begin
                if (mem_rvalid) begin
                    if (mem_err) begin
                        stall_set = 1'b1;
                        nxt       = ST_IDLE;
                    end else begin
                        cap = 1'b1;
                        nxt = ST_SORT;
                    end
                end
            end
            ST_SORT: begin
                if (act == ACT_ISSUE) begin
                    nxt = ST_ISSUE;
                end else begin
                    rd_load = 1'b1;
                    nxt     = ST_CHECK;
                end
            end
            ST_ISSUE: begin
                if (cmd_done) begin
                    if (cmd_stall) begin
                        stall_set = 1'b1;
                        nxt       = ST_IDLE;
                    end else begin
                        rd_load = 1'b1;
                        nxt     = ST_CHECK;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pend  <= 1'b0;
            cmd_q <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE) pend <= 1'b0;
            else if (kick)        pend <= 1'b1;
            if (cap) cmd_q <= mem_rdata;
        end
    end

    AST_FETCH_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(enable)); // R1

    AST_FETCH_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (CNT_W'(rd_off) < slot_cnt)); // R3

    AST_DISPATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_words))); // R12

    AST_NO_SYNC_ISSUE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_opcode != OP_SYNC)); // R10

    AST_ISSUE_KNOWN_OP: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> op_in_range(cmd_opcode)); // R11

endmodule

// File: rtl/cmdq_consumer.sv
module cmdq_consumer
    import cq_pkg::*;
#(
    parameter int SIZE_W  = 8,
    parameter int ADDR_W  = 52,
    parameter int NUM_TBL = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [REG_AW-1:0]     reg_waddr,
    input  logic [WORD_W-1:0]     reg_wdata,
    input  logic [REG_AW-1:0]     reg_raddr,
    output logic [WORD_W-1:0]     reg_rdata,
    input  logic                  sec_off,
    output logic                  mem_req,
    output logic [ADDR_W-1:0]     mem_addr,
    input  logic                  mem_rvalid,
    input  logic [CMD_W-1:0]      mem_rdata,
    input  logic                  mem_err,
    output logic                  cmd_valid,
    output logic [OPC_W-1:0]      cmd_opcode,
    output logic [CMD_W-1:0]      cmd_words,
    input  logic                  cmd_done,
    input  logic                  cmd_stall
);

    localparam int OFF_W = SIZE_W + 7;

    logic                         enable, q_valid, stalled, kick, busy;
    logic [ADDR_W-PAGE_SHIFT-1:0] q_page;
    logic [SIZE_W-1:0]            q_size;
    logic [OFF_W-1:0]             wr_off, rd_off, rd_val;
    logic                         rd_load, stall_set;

    cq_regfile #(
        .SIZE_W  (SIZE_W),
        .ADDR_W  (ADDR_W),
        .NUM_TBL (NUM_TBL)
    ) u_regs (
        .clk          (clk),
        .rst          (rst),
        .reg_we       (reg_we),
        .reg_waddr    (reg_waddr),
        .reg_wdata    (reg_wdata),
        .reg_raddr    (reg_raddr),
        .reg_rdata    (reg_rdata),
        .sec_off      (sec_off),
        .busy         (busy),
        .hw_rd_load   (rd_load),
        .hw_rd_val    (rd_val),
        .hw_stall_set (stall_set),
        .enable       (enable),
        .q_valid      (q_valid),
        .q_page       (q_page),
        .q_size       (q_size),
        .wr_off       (wr_off),
        .rd_off       (rd_off),
        .stalled      (stalled),
        .kick         (kick)
    );

    cq_sequencer #(
        .SIZE_W (SIZE_W),
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .kick       (kick),
        .q_valid    (q_valid),
        .q_page     (q_page),
        .q_size     (q_size),
        .wr_off     (wr_off),
        .rd_off     (rd_off),
        .busy       (busy),
        .rd_load    (rd_load),
        .rd_val     (rd_val),
        .stall_set  (stall_set),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .mem_err    (mem_err),
        .cmd_valid  (cmd_valid),
        .cmd_opcode (cmd_opcode),
        .cmd_words  (cmd_words),
        .cmd_done   (cmd_done),
        .cmd_stall  (cmd_stall)
    );

    AST_STALL_HOLDS_PTR: assert property (@(posedge clk) disable iff (rst)
        (stall_set && !rd_load) |=> $stable(rd_off)); // R6

endmodule

// File: tb/cmdq_consumer_test.sv
module cmdq_consumer_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] BASE = 64'h10000;
    localparam logic [63:0] QB   = (64'h1 << 63) | BASE;
    localparam logic [40:0] VEC [8] = '{
        {8'h03, 16'h0000, 16'h0000, 1'b1},
        {8'h05, 16'h0000, 16'h0000, 1'b0},
        {8'h0E, 16'h0007, 16'h0007, 1'b0},
        {8'h0E, 16'h0002, 16'h0005, 1'b1},
        {8'h20, 16'h0000, 16'h0000, 1'b0},
        {8'h00, 16'h0000, 16'h0000, 1'b0},
        {8'h0F, 16'h0000, 16'h0000, 1'b1},
        {8'h01, 16'h0000, 16'h0000, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_waddr = '0;
    logic [63:0]  reg_wdata = '0;
    logic [2:0]   reg_raddr = '0;
    logic [63:0]  reg_rdata;
    logic         sec_off = 1'b0;
    logic         mem_req;
    logic [51:0]  mem_addr;
    logic         mem_rvalid = 1'b0;
    logic [255:0] mem_rdata = '0;
    logic         mem_err = 1'b0;
    logic         cmd_valid;
    logic [7:0]   cmd_opcode;
    logic [255:0] cmd_words;
    logic         cmd_done = 1'b0;
    logic         cmd_stall = 1'b0;

    logic [255:0] qmem [64];
    logic [51:0]  err_addr = '1;
    logic [51:0]  last_addr = '0;
    logic [7:0]   stall_op = 8'hFF;
    logic [7:0]   last_op = '0;
    logic [7:0]   h_op = '0;
    int           fetch_cnt = 0;
    int           disp_cnt = 0;
    int           mdly = 0;
    int           hcnt = 0;
    int           checks = 0;
    int           fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdq_consumer uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .sec_off(sec_off), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_words(cmd_words),
        .cmd_done(cmd_done), .cmd_stall(cmd_stall)
    );

    function automatic logic [255:0] mk(input logic [7:0] op, input logic [15:0] src,
                                        input logic [15:0] dst);
        logic [63:0] w0, w2, w3;
        w0 = {56'h0, op};
        w2 = {32'h0, src, 16'h0};
        w3 = {32'h0, dst, 16'h0};
        return {w3, w2, 64'h0, w0};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [63:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // memory responder: answers two negedges after a request appears
    always @(negedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid = 1'b0;
            mem_err    = 1'b0;
        end else if (mem_req) begin
            if (mdly == 1) begin
                mem_rvalid = 1'b1;
                mem_rdata  = qmem[mem_addr[10:5]];
                mem_err    = (mem_addr == err_addr);
                last_addr  = mem_addr;
                fetch_cnt++;
                mdly = 0;
            end else begin
                mdly++;
            end
        end
    end

    // handler responder, also checks hold of the presented command
    always @(negedge clk) begin
        if (cmd_done) begin
            cmd_done = 1'b0;
            hcnt = 0;
        end else if (cmd_valid) begin
            if (hcnt == 0) h_op = cmd_opcode;
            if (hcnt == 2) begin
                chk("R12 opcode held", {56'h0, cmd_opcode}, {56'h0, h_op});
                cmd_done  = 1'b1;
                cmd_stall = (cmd_opcode == stall_op);
                last_op   = cmd_opcode;
                disp_cnt++;
                hcnt = 0;
            end else begin
                hcnt++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [63:0] v;
        int d0, f0;
        for (int i = 0; i < 64; i++) qmem[i] = mk(8'h03, 16'h0, 16'h0);
        for (int i = 0; i < 8; i++) qmem[i] = mk(VEC[i][40:33], VEC[i][32:17], VEC[i][16:1]);
        qmem[11] = mk(8'h0A, 16'h0, 16'h0);
        qmem[63] = mk(8'h01, 16'h0, 16'h0);

        idle(3);
        rst = 1'b0;
        idle(1);
        rd(3'd0, v); chk("R1 reset enable", v, 64'h0);
        rd(3'd3, v); chk("R9 reset read ptr", v, 64'h0);
        chk("R1 reset no fetch", {63'h0, mem_req}, 64'h0);
        chk("R12 reset no dispatch", {63'h0, cmd_valid}, 64'h0);

        wr(3'd1, QB);           rd(3'd1, v); chk("R8 ring base while disabled", v, QB);
        wr(3'd4, 64'hABCD000);  rd(3'd4, v); chk("R8 table base while disabled", v, 64'hABCD000);
        wr(3'd0, 64'h1);        rd(3'd0, v); chk("R1 enable set", v, 64'h1);
        wr(3'd1, 64'h0);        rd(3'd1, v); chk("R8 ring base frozen", v, QB);
        wr(3'd4, 64'h0);        rd(3'd4, v); chk("R8 table base frozen", v, 64'hABCD000);

        // vector walk: one command per step
        for (int i = 0; i < 8; i++) begin
            d0 = disp_cnt;
            wr(3'd2, 64'(i + 1) << 5);
            idle(40);
            rd(3'd3, v); chk("R5 read ptr advance", v, 64'(i + 1) << 5);
            chk("R10/R11 dispatch decision", 64'(disp_cnt - d0), {63'h0, VEC[i][0]});
            if (VEC[i][0]) chk("R11 opcode presented", {56'h0, last_op}, {56'h0, VEC[i][40:33]});
            chk("R4 fetch address", {12'h0, last_addr}, BASE + 64'(i) * 32);
        end

        // retry bit masked, same offset starts nothing
        f0 = fetch_cnt;
        wr(3'd2, (64'd8 << 5) | 64'h1);
        idle(20);
        rd(3'd2, v); chk("R7 retry bit reads 0", v, 64'd8 << 5);
        chk("R7 no fetch on equal pointer", 64'(fetch_cnt - f0), 64'h0);

        // batch in one pass
        d0 = disp_cnt;
        wr(3'd2, 64'd11 << 5);
        idle(80);
        rd(3'd3, v); chk("R4 batch drained", v, 64'd11 << 5);
        chk("R4 batch dispatches", 64'(disp_cnt - d0), 64'd3);

        // handler stall
        stall_op = 8'h0A;
        d0 = disp_cnt;
        wr(3'd2, 64'd13 << 5);
        idle(60);
        rd(3'd3, v); chk("R6 stall holds pointer", v, (64'd11 << 5) | 64'h1);
        chk("R6 stall ends pass", 64'(disp_cnt - d0), 64'd1);

        // sticky flag through a later pass
        stall_op = 8'hFF;
        wr(3'd2, 64'd13 << 5);
        idle(60);
        rd(3'd3, v); chk("R6 sticky after resume", v, (64'd13 << 5) | 64'h1);

        // read pointer access rules and wrap
        wr(3'd3, 64'd5 << 5);
        rd(3'd3, v); chk("R9 write ignored when secure", v, (64'd13 << 5) | 64'h1);
        sec_off = 1'b1;
        wr(3'd3, (64'd127 << 5) | 64'h1);
        rd(3'd3, v); chk("R9 write loads offset, clears flag", v, 64'd127 << 5);
        d0 = disp_cnt;
        wr(3'd2, 64'd1 << 5);
        idle(60);
        rd(3'd3, v); chk("R5 wrap to slot 0", v, 64'd1 << 5);
        chk("R5 fetch after wrap at slot 0", {12'h0, last_addr}, BASE);
        chk("R5 both slots dispatched", 64'(disp_cnt - d0), 64'd2);

        // fetch error
        err_addr = 52'(BASE + 64'd32);
        d0 = disp_cnt;
        wr(3'd2, 64'd2 << 5);
        idle(40);
        rd(3'd3, v); chk("R6 fetch error stalls", v, (64'd1 << 5) | 64'h1);
        chk("R6 fetch error no dispatch", 64'(disp_cnt - d0), 64'h0);
        err_addr = '1;
        wr(3'd3, 64'd1 << 5);
        rd(3'd3, v); chk("R9 flag cleared by write", v, 64'd1 << 5);

        // out of range offsets
        wr(3'd3, 64'd200 << 5);
        f0 = fetch_cnt;
        wr(3'd2, 64'd5 << 5);
        idle(30);
        chk("R3 read offset too large", 64'(fetch_cnt - f0), 64'h0);
        rd(3'd3, v); chk("R3 read ptr kept", v, 64'd200 << 5);
        wr(3'd3, 64'd1 << 5);
        wr(3'd2, 64'd300 << 5);
        idle(30);
        chk("R3 write offset too large", 64'(fetch_cnt - f0), 64'h0);
        rd(3'd3, v); chk("R3 read ptr kept on bad write offset", v, 64'd1 << 5);

        // two pages, enable gating
        wr(3'd0, 64'h0);
        wr(3'd1, QB | 64'h1);
        wr(3'd3, 64'd200 << 5);
        wr(3'd2, 64'd201 << 5);
        idle(20);
        chk("R1 no fetch while disabled", 64'(fetch_cnt - f0), 64'h0);
        wr(3'd0, 64'h1);
        idle(40);
        rd(3'd3, v); chk("R2 two-page ring holds slot 200", v, 64'd201 << 5);
        chk("R4 address of slot 200", {12'h0, last_addr}, BASE + 64'd200 * 32);

        // valid bit clear gives zero slots
        f0 = fetch_cnt;
        wr(3'd0, 64'h0);
        wr(3'd1, BASE);
        wr(3'd3, 64'h0);
        wr(3'd2, 64'd1 << 5);
        wr(3'd0, 64'h1);
        idle(30);
        chk("R2 invalid ring fetches nothing", 64'(fetch_cnt - f0), 64'h0);
        rd(3'd3, v); chk("R2 invalid ring keeps pointer", v, 64'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule